// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block watches a small set of asynchronous capture inputs, brings each one into the local clock domain and finds its rising and falling edges. When a channel sees an edge it has been told to watch, it copies the timer count it receives on an input port into that channel's capture register. If the channel's interrupt enable is set, it also sets that channel's sticky capture flag. Software clears a flag by writing a one to it.

The same edge information also drives the counter's increment source. In clock mode the count-enable output is high on every cycle. In the three edge-count modes it gives a one-cycle pulse for each qualifying edge on one selected input, so an external counter can count input transitions instead of clock ticks. The edge select for capture and the edge select for counting are independent of each other. The counter, the match logic and the register bus all sit outside this block.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, every capture register reads 0 and every capture flag reads 0.
- R2: The capture control word holds a 3-bit group per channel, and channel n's group starts at bit 3*n. Within the group, bit 0 enables rising-edge capture, bit 1 enables falling-edge capture and bit 2 enables the interrupt flag.
- R3: With only the rising enable set, a rising input edge loads the count value into the capture register. The input changes just after a clock edge. The capture register and the flag update on the third rising clock edge after that change.
- R4: With only the falling enable set, a falling edge captures and a rising edge does not.
- R5: With both enables set, both rising and falling edges capture.
- R6: With both edge enables clear, the channel's capture register never changes and its flag is never set.
- R7: A capture sets the channel's flag only when that channel's interrupt enable is set. The capture register updates either way.
- R8: A one on clr_flags[n] clears flag n on the next clock edge. A zero leaves the flag unchanged.
- R9: When a capture and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: In counter-source mode 0, count_en is high on every cycle.
- R11: Modes 1, 2 and 3 pulse count_en for exactly one cycle on each rising edge, each falling edge or each edge of either kind, respectively, of the input chosen by cnt_sel. The pulse is high in the cycle after the second clock edge following the input change.
- R12: In edge-count modes, edges on inputs that cnt_sel does not choose produce no count_en pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | NUM_CH | Asynchronous capture inputs |
| count_val | input | CNT_W | Current timer count to be captured |
| cap_ctrl | input | 3*NUM_CH | Per-channel group {irq_en, fall_en, rise_en} at bit 3*n |
| clr_flags | input | NUM_CH | Write-one-to-clear strobe for the capture flags |
| cnt_mode | input | 2 | Counter source: 0 clock, 1 rise, 2 fall, 3 both edges |
| cnt_sel | input | SEL_W | Index of the input that drives counting in modes 1 to 3 |
| cap_value | output | NUM_CH*CNT_W | Capture registers; channel n in bits n*CNT_W upward |
| cap_flags | output | NUM_CH | Sticky capture flags |
| count_en | output | 1 | Increment enable for the external counter |

## Verification
The hardest case to reach is a capture and a flag clear landing in the same clock cycle. The clear has to be lined up with the internal edge pulse, which only exists two synchroniser stages after the pin changes. The stimulus drives the input just after a clock edge, waits exactly two clock edges and then asserts the clear for one cycle, so the two events meet. A scoreboard queue holds the count value each driven edge should capture. Any capture register change that has no matching entry, or a missing capture, is reported.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        SRC_CLOCK = 2'd0,
        SRC_RISE  = 2'd1,
        SRC_FALL  = 2'd2,
        SRC_BOTH  = 2'd3
    } cnt_src_e;

    // Per-channel control group, LSB first: rise, fall, irq
    typedef struct packed {
        logic irq_en;
        logic fall_en;
        logic rise_en;
    } cap_cfg_t;

    function automatic logic edge_hit(input logic rise_en, input logic fall_en,
                                      input logic rise, input logic fall);
        return (rise_en & rise) | (fall_en & fall);
    endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int NUM_CH = 4,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] async_in,
    output logic [NUM_CH-1:0] rise,
    output logic [NUM_CH-1:0] fall
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][NUM_CH-1:0] chain;
        logic [NUM_CH-1:0]             prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.chain[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            sync_d.chain[k] = sync_q.chain[k-1];
        end
        sync_d.prev = sync_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise = sync_q.chain[LAST] & ~sync_q.prev;
    assign fall = ~sync_q.chain[LAST] & sync_q.prev;

endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fall,
    input  cap_cfg_t         cfg,
    input  logic [CNT_W-1:0] count_val,
    input  logic             clr,
    output logic [CNT_W-1:0] value,
    output logic             flag
);

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             flag;
    } chan_t;

    chan_t ch_d, ch_q;
    logic  hit;

    always_comb begin
        hit  = edge_hit(cfg.rise_en, cfg.fall_en, rise, fall);
        ch_d = ch_q;
        if (hit) ch_d.value = count_val;
        // a set in the same cycle overrides the clear
        if (hit && cfg.irq_en) ch_d.flag = 1'b1;
        else if (clr)          ch_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign value = ch_q.value;
    assign flag  = ch_q.flag;

endmodule

// File: rtl/cap_cnt_src.sv
module cap_cnt_src
    import cap_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = 2
) (
    input  logic [1:0]        mode,
    input  logic [SEL_W-1:0]  sel,
    input  logic [NUM_CH-1:0] rise,
    input  logic [NUM_CH-1:0] fall,
    output logic              count_en
);

    logic sel_rise, sel_fall;

    always_comb begin
        sel_rise = 1'b0;
        sel_fall = 1'b0;
        if (int'(sel) < NUM_CH) begin
            sel_rise = rise[sel];
            sel_fall = fall[sel];
        end
        unique case (cnt_src_e'(mode))
            SRC_CLOCK: count_en = 1'b1;
            SRC_RISE:  count_en = sel_rise;
            SRC_FALL:  count_en = sel_fall;
            SRC_BOTH:  count_en = sel_rise | sel_fall;
            default:   count_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import cap_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       cap_in,
    input  logic [CNT_W-1:0]        count_val,
    input  logic [3*NUM_CH-1:0]     cap_ctrl,
    input  logic [NUM_CH-1:0]       clr_flags,
    input  logic [1:0]              cnt_mode,
    input  logic [SEL_W-1:0]        cnt_sel,
    output logic [NUM_CH*CNT_W-1:0] cap_value,
    output logic [NUM_CH-1:0]       cap_flags,
    output logic                    count_en
);

    localparam int GRP_W = 3;

    logic [NUM_CH-1:0] rise, fall;

    cap_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cap_in),
        .rise     (rise),
        .fall     (fall)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        cap_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .rise      (rise[n]),
            .fall      (fall[n]),
            .cfg       (cap_cfg_t'(cap_ctrl[GRP_W*n +: GRP_W])),
            .count_val (count_val),
            .clr       (clr_flags[n]),
            .value     (cap_value[CNT_W*n +: CNT_W]),
            .flag      (cap_flags[n])
        );
    end

    cap_cnt_src #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_src (
        .mode     (cnt_mode),
        .sel      (cnt_sel),
        .rise     (rise),
        .fall     (fall),
        .count_en (count_en)
    );

endmodule

// File: rtl/edge_capture_unit_chk.sv
module edge_capture_unit_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [3*NUM_CH-1:0]     cap_ctrl,
    input logic [NUM_CH-1:0]       clr_flags,
    input logic [1:0]              cnt_mode,
    input logic                    count_en,
    input logic [NUM_CH*CNT_W-1:0] cap_value,
    input logic [NUM_CH-1:0]       cap_flags
);

    p_clock_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode == 2'd0) |-> count_en);

    p_rise_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode == 2'd1 && count_en) |=> (cnt_mode != 2'd1 || !count_en));

    p_fall_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode == 2'd2 && count_en) |=> (cnt_mode != 2'd2 || !count_en));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        p_no_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!cap_ctrl[3*i] && !cap_ctrl[3*i+1]) |=> $stable(cap_value[CNT_W*i +: CNT_W]));

        p_flag_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!cap_ctrl[3*i+2] && !cap_flags[i]) |=> !cap_flags[i]);

        p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_flags[i] && !cap_ctrl[3*i] && !cap_ctrl[3*i+1]) |=> !cap_flags[i]);
    end

endmodule

bind edge_capture_unit edge_capture_unit_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_ctrl  (cap_ctrl),
    .clr_flags (clr_flags),
    .cnt_mode  (cnt_mode),
    .count_en  (count_en),
    .cap_value (cap_value),
    .cap_flags (cap_flags)
);

// File: tb/edge_capture_unit_bench.sv
`timescale 1ns/1ps
module edge_capture_unit_bench;

    localparam int NUM_CH = 4;
    localparam int CNT_W  = 32;
    localparam int SEL_W  = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NUM_CH-1:0]       cap_in = '0;
    logic [CNT_W-1:0]        count_val = '0;
    logic [3*NUM_CH-1:0]     cap_ctrl = '0;
    logic [NUM_CH-1:0]       clr_flags = '0;
    logic [1:0]              cnt_mode = 2'd0;
    logic [SEL_W-1:0]        cnt_sel = '0;
    logic [NUM_CH*CNT_W-1:0] cap_value;
    logic [NUM_CH-1:0]       cap_flags;
    logic                    count_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int               exp_ch[$];
    logic [CNT_W-1:0] exp_val[$];
    logic [CNT_W-1:0] snap [NUM_CH];

    always #10 clk = ~clk;

    edge_capture_unit #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_edge_capture_unit (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .count_val(count_val),
        .cap_ctrl(cap_ctrl), .clr_flags(clr_flags), .cnt_mode(cnt_mode),
        .cnt_sel(cnt_sel), .cap_value(cap_value), .cap_flags(cap_flags),
        .count_en(count_en)
    );

    task automatic chk_eq(input string tag, input logic [CNT_W-1:0] act,
                          input logic [CNT_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every capture register change must match the head of the queue
    initial for (int c = 0; c < NUM_CH; c++) snap[c] = '0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (cap_value[CNT_W*c +: CNT_W] !== snap[c]) begin
                    if (exp_ch.size() == 0) begin
                        chk_eq("R6 unexpected capture", cap_value[CNT_W*c +: CNT_W], snap[c]);
                    end else begin
                        chk_eq("R3 scoreboard channel", CNT_W'(c), CNT_W'(exp_ch.pop_front()));
                        chk_eq("R3 scoreboard value", cap_value[CNT_W*c +: CNT_W], exp_val.pop_front());
                    end
                    snap[c] = cap_value[CNT_W*c +: CNT_W];
                end
            end
        end
    end

    // Driver: change one input, present a count value, queue the expectation
    task automatic drive_edge(input int ch, input logic lvl, input logic [CNT_W-1:0] v,
                              input bit expect_cap);
        @(negedge clk);
        count_val  = v;
        cap_in[ch] = lvl;
        if (expect_cap) begin
            exp_ch.push_back(ch);
            exp_val.push_back(v);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic clear(input logic [NUM_CH-1:0] m);
        @(negedge clk); clr_flags = m;
        @(negedge clk); clr_flags = '0;
    endtask

    task automatic count_window(input int ch, input logic lvl, output int n);
        @(negedge clk); cap_in[ch] = lvl;
        n = 0;
        repeat (6) begin
            @(negedge clk);
            if (count_en) n++;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NUM_CH; c++)
            chk_eq("R1 reset capture value", cap_value[CNT_W*c +: CNT_W], '0);
        chk_eq("R1 reset flags", CNT_W'(cap_flags), '0);

        // R2 groups: ch3 irq only, ch2 both+irq, ch1 fall only, ch0 rise+irq
        cap_ctrl = {3'b100, 3'b111, 3'b010, 3'b101};

        // R3 exact latency on ch0 rising edge
        @(negedge clk);
        count_val = 32'h100;
        cap_in[0] = 1'b1;
        exp_ch.push_back(0); exp_val.push_back(32'h100);
        @(negedge clk);
        @(negedge clk);
        chk_eq("R3 flag not yet set after two edges", CNT_W'(cap_flags[0]), 0);
        @(negedge clk);
        chk_eq("R3 flag set on third edge", CNT_W'(cap_flags[0]), 1);
        chk_eq("R3 R2 ch0 captured value", cap_value[31:0], 32'h100);
        repeat (2) @(negedge clk);

        // R8 write-one-to-clear
        clear(4'b0000);
        chk_eq("R8 zero write keeps flag", CNT_W'(cap_flags[0]), 1);
        clear(4'b0001);
        chk_eq("R8 one write clears flag", CNT_W'(cap_flags[0]), 0);

        // R3 falling edge on rise-only channel is ignored
        drive_edge(0, 1'b0, 32'h101, 0);
        chk_eq("R3 fall ignored on rise-only ch0", cap_value[31:0], 32'h100);
        chk_eq("R3 no flag from ignored edge", CNT_W'(cap_flags[0]), 0);

        // R4 / R7 fall-only channel without irq
        drive_edge(1, 1'b1, 32'h1ff, 0);
        chk_eq("R4 rise ignored on fall-only ch1", cap_value[63:32], 0);
        drive_edge(1, 1'b0, 32'h200, 1);
        chk_eq("R4 R2 ch1 falling capture", cap_value[63:32], 32'h200);
        chk_eq("R7 no flag without irq enable", CNT_W'(cap_flags[1]), 0);

        // R5 both edges on ch2
        drive_edge(2, 1'b1, 32'h300, 1);
        chk_eq("R5 ch2 rising capture", cap_value[95:64], 32'h300);
        drive_edge(2, 1'b0, 32'h301, 1);
        chk_eq("R5 R2 ch2 falling capture", cap_value[95:64], 32'h301);
        chk_eq("R7 flag with irq enable", CNT_W'(cap_flags[2]), 1);

        // R6 ch3 has no edge enables
        drive_edge(3, 1'b1, 32'h400, 0);
        drive_edge(3, 1'b0, 32'h401, 0);
        chk_eq("R6 ch3 value unchanged", cap_value[127:96], 0);
        chk_eq("R6 ch3 flag never set", CNT_W'(cap_flags[3]), 0);

        // R9 capture and clear in the same cycle on ch2
        @(negedge clk);
        count_val = 32'h500;
        cap_in[2] = 1'b1;
        exp_ch.push_back(2); exp_val.push_back(32'h500);
        @(negedge clk);
        @(negedge clk);
        clr_flags = 4'b0100;
        @(negedge clk);
        clr_flags = '0;
        chk_eq("R9 capture wins over clear", CNT_W'(cap_flags[2]), 1);
        repeat (2) @(negedge clk);
        clear(4'b0100);
        chk_eq("R8 clear after collision", CNT_W'(cap_flags[2]), 0);

        // Counter-source modes, capture disabled
        cap_ctrl = '0;
        cap_in   = '0;
        repeat (4) @(negedge clk);
        cnt_mode = 2'd0;
        n = 0;
        repeat (5) begin
            @(negedge clk);
            if (count_en) n++;
        end
        chk_eq("R10 clock mode enables every cycle", n, 5);

        // R11 exact pulse cycle, mode 1 on input 1
        cnt_mode = 2'd1;
        cnt_sel  = 2'd1;
        @(negedge clk);
        cap_in[1] = 1'b1;
        @(negedge clk);
        chk_eq("R11 no pulse after one edge", CNT_W'(count_en), 0);
        @(negedge clk);
        chk_eq("R11 pulse after two edges", CNT_W'(count_en), 1);
        @(negedge clk);
        chk_eq("R11 pulse one cycle wide", CNT_W'(count_en), 0);
        repeat (3) @(negedge clk);
        count_window(1, 1'b0, n);
        chk_eq("R11 mode 1 ignores falling edge", n, 0);

        cnt_mode = 2'd2;
        count_window(1, 1'b1, n);
        chk_eq("R11 mode 2 ignores rising edge", n, 0);
        count_window(1, 1'b0, n);
        chk_eq("R11 mode 2 falling pulse", n, 1);

        cnt_mode = 2'd3;
        count_window(1, 1'b1, n);
        chk_eq("R11 mode 3 rising pulse", n, 1);
        count_window(1, 1'b0, n);
        chk_eq("R11 mode 3 falling pulse", n, 1);

        // R12 non-selected inputs
        count_window(0, 1'b1, n);
        chk_eq("R12 unselected rise", n, 0);
        count_window(3, 1'b1, n);
        chk_eq("R12 unselected rise ch3", n, 0);
        cnt_sel = 2'd3;
        count_window(3, 1'b0, n);
        chk_eq("R12 reselected input pulses", n, 1);

        chk_eq("R3 scoreboard drained", exp_ch.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule